// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block is the processor-facing control store for a small USB device endpoint engine with seven hardware endpoints, numbered 0 to 6. The processor reaches it over a byte-wide register bus with a two-bit address. An index register chooses which endpoint the shared control register refers to. One bus location therefore serves every endpoint, and each endpoint keeps its own enable bit and its own pending-STALL state.

The protocol engine sends per-endpoint event pulses into the bank: one when a STALL handshake has gone out, and one when a SETUP token arrives. Either pulse withdraws that endpoint's pending STALL. The bank drives four level vectors back to the endpoint logic: enable, STALL request, a one-cycle data-toggle reset pulse, and FIFO reset. The FIFO reset register has one bit for each of endpoints 0 to 4. Endpoints 5 and 6 have no FIFO reset bit.

Register map by `bus_addr`:

- Address 0 is the endpoint index register.
- Address 1 is the control register of the selected endpoint.
- Address 2 is the FIFO reset register.
- Address 3 reads zero and ignores writes.

Reads are combinational from `bus_addr`. Writes take effect at the rising clock edge on which `bus_we` is high.

Top module: `usb_ep_ctl_bank`

## Requirements
- R1: After reset every output vector is zero and all four register addresses read zero.
- R2: Address 0 stores `bus_wdata[2:0]` as the endpoint index. Its bits 7:3 always read zero, and address 3 always reads zero.
- R3: Address 1 reads and writes only the endpoint given by the index. Bit 0 is the enable, and it drives that endpoint's bit of `ep_enable` from the cycle after the write. On a read, bit 5 shows the pending STALL, bit 0 shows the enable, and every other bit is zero.
- R4: Writing address 1 with bit 5 set arms the STALL request of the selected endpoint. A write with bit 5 clear leaves the STALL request unchanged.
- R5: A pulse on `evt_stall_sent[i]` or on `evt_setup_rx[i]` clears `ep_stall_req[i]` at the next edge.
- R6: Writing address 1 with bit 4 set cancels the pending STALL of the selected endpoint.
- R7: Writing address 1 with bit 3 set raises the selected endpoint's bit of `ep_toggle_rst` for exactly the one cycle after the write. At most one endpoint pulses in any cycle.
- R8: Address 2 holds one FIFO reset bit for each of endpoints 0 to 4, in bits 4:0. Each bit drives `ep_fifo_rst` for as long as it is one. Bits 7:5 read zero, and `ep_fifo_rst[6:5]` stays zero.
- R9: A hardware clear event (R5) and a set request (R4) that reach the same endpoint in the same cycle leave that endpoint's STALL request at zero. A bit 4 cancel (R6) in the same write as a bit 5 set also leaves it at zero.
- R10: While the index is 7, address 1 reads zero and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| evt_stall_sent | input | 7 | Per-endpoint pulse: STALL handshake sent |
| evt_setup_rx | input | 7 | Per-endpoint pulse: SETUP token received |
| ep_enable | output | 7 | Per-endpoint enable level |
| ep_stall_req | output | 7 | Per-endpoint pending STALL request |
| ep_toggle_rst | output | 7 | Per-endpoint one-cycle data-toggle reset pulse |
| ep_fifo_rst | output | 7 | Per-endpoint FIFO reset level |

## Verification
Two things can act on the same endpoint in one cycle: a processor write to the control register that arms a STALL, and a STALL-sent or SETUP pulse from the protocol engine that clears it. The random phase drives sparse event pulses on every endpoint while it issues control writes with bit 5 set much of the time, so such collisions occur often. Directed steps also force a collision on the selected endpoint, and another step sets bits 5 and 4 in the same write. A reference model in the bench applies the clear-over-set priority and judges the result on `ep_stall_req` and on the read-back value.

// File: rtl/usb_epc_pkg.sv
package usb_epc_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SEL  = 2'd0,
    REG_CTL  = 2'd1,
    REG_FRST = 2'd2,
    REG_NONE = 2'd3
  } reg_addr_e;

  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_TGL_BIT   = 3;
  localparam int CTL_STCLR_BIT = 4;
  localparam int CTL_STREQ_BIT = 5;

  // Read image of the control register: only the two live levels appear.
  function automatic logic [DATA_W-1:0] ctl_pack(input logic en, input logic stall);
    logic [DATA_W-1:0] r;
    r = '0;
    r[CTL_EN_BIT]    = en;
    r[CTL_STREQ_BIT] = stall;
    return r;
  endfunction

  // Next pending-STALL state: a clear source always outranks a set.
  function automatic logic stall_next(input logic cur, input logic set, input logic clr);
    if (clr) return 1'b0;
    if (set) return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/usb_epc_sel.sv
module usb_epc_sel #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wdata,
  output logic [SEL_W-1:0] sel_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sel_q <= '0;
    else if (wr_en) sel_q <= wdata;
  end

endmodule

// File: rtl/usb_epc_frst.sv
module usb_epc_frst #(
  parameter int RST_EP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [RST_EP-1:0] wdata,
  output logic [RST_EP-1:0] rst_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rst_q <= '0;
    else if (wr_en) rst_q <= wdata;
  end

endmodule

// File: rtl/usb_epc_slice.sv
module usb_epc_slice
  import usb_epc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              hw_clr,
  output logic              en_q,
  output logic              stall_q,
  output logic              tgl_q
);

  logic stall_arm;
  logic stall_drop;

  assign stall_arm  = wr_hit & wdata[CTL_STREQ_BIT];
  assign stall_drop = hw_clr | (wr_hit & wdata[CTL_STCLR_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      stall_q <= 1'b0;
      tgl_q   <= 1'b0;
    end else begin
      if (wr_hit) en_q <= wdata[CTL_EN_BIT];
      stall_q <= stall_next(stall_q, stall_arm, stall_drop);
      tgl_q   <= wr_hit & wdata[CTL_TGL_BIT];
    end
  end

endmodule

// File: rtl/usb_ep_ctl_bank.sv
module usb_ep_ctl_bank
  import usb_epc_pkg::*;
#(
  parameter int NUM_EP = 7,
  parameter int RST_EP = 5,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [NUM_EP-1:0] evt_stall_sent,
  input  logic [NUM_EP-1:0] evt_setup_rx,
  output logic [NUM_EP-1:0] ep_enable,
  output logic [NUM_EP-1:0] ep_stall_req,
  output logic [NUM_EP-1:0] ep_toggle_rst,
  output logic [NUM_EP-1:0] ep_fifo_rst
);

  localparam int SLOTS = 1 << SEL_W;

  logic              wr_sel;
  logic              wr_ctl;
  logic              wr_frst;
  logic [SEL_W-1:0]  sel_q;
  logic              sel_valid;
  logic [NUM_EP-1:0] hw_clr;
  logic [NUM_EP-1:0] ctl_hit;
  logic [RST_EP-1:0] frst_q;
  logic [SLOTS-1:0]  en_slot;
  logic [SLOTS-1:0]  stall_slot;

  assign wr_sel    = bus_we && (bus_addr == REG_SEL);
  assign wr_ctl    = bus_we && (bus_addr == REG_CTL);
  assign wr_frst   = bus_we && (bus_addr == REG_FRST);
  assign sel_valid = (int'(sel_q) < NUM_EP);
  assign hw_clr    = evt_stall_sent | evt_setup_rx;

  usb_epc_sel #(.SEL_W(SEL_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_sel),
    .wdata (bus_wdata[SEL_W-1:0]),
    .sel_q (sel_q)
  );

  usb_epc_frst #(.RST_EP(RST_EP)) u_frst (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_frst),
    .wdata (bus_wdata[RST_EP-1:0]),
    .rst_q (frst_q)
  );

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign ctl_hit[i] = wr_ctl && (sel_q == SEL_W'(i));
    usb_epc_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (ctl_hit[i]),
      .wdata   (bus_wdata),
      .hw_clr  (hw_clr[i]),
      .en_q    (ep_enable[i]),
      .stall_q (ep_stall_req[i]),
      .tgl_q   (ep_toggle_rst[i])
    );
  end

  // Pad the per-endpoint levels out to every index value.
  if (SLOTS > NUM_EP) begin : g_pad
    assign en_slot    = {{(SLOTS-NUM_EP){1'b0}}, ep_enable};
    assign stall_slot = {{(SLOTS-NUM_EP){1'b0}}, ep_stall_req};
  end else begin : g_nopad
    assign en_slot    = ep_enable[SLOTS-1:0];
    assign stall_slot = ep_stall_req[SLOTS-1:0];
  end

  if (NUM_EP > RST_EP) begin : g_frst_pad
    assign ep_fifo_rst = {{(NUM_EP-RST_EP){1'b0}}, frst_q};
  end else begin : g_frst_full
    assign ep_fifo_rst = frst_q[NUM_EP-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_SEL:  bus_rdata[SEL_W-1:0] = sel_q;
      REG_CTL:  if (sel_valid) bus_rdata = ctl_pack(en_slot[sel_q], stall_slot[sel_q]);
      REG_FRST: bus_rdata[RST_EP-1:0] = frst_q;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/usb_ep_ctl_bank_chk.sv
module usb_ep_ctl_bank_chk #(
  parameter int NUM_EP = 7,
  parameter int RST_EP = 5,
  parameter int SEL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [NUM_EP-1:0] evt_stall_sent,
  input logic [NUM_EP-1:0] evt_setup_rx,
  input logic [NUM_EP-1:0] ep_enable,
  input logic [NUM_EP-1:0] ep_stall_req,
  input logic [NUM_EP-1:0] ep_toggle_rst,
  input logic [NUM_EP-1:0] ep_fifo_rst,
  input logic [SEL_W-1:0]  sel_q
);

  logic [NUM_EP-1:0] clr_src;
  assign clr_src = evt_stall_sent | evt_setup_rx;

  AST_SEL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[7:SEL_W] == '0)); // R2

  AST_CTL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1) |-> ((bus_rdata & 8'hDE) == 8'h00)); // R3

  AST_STALL_HOLD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1 && !bus_wdata[5] && !bus_wdata[4] && clr_src == '0)
    |=> (ep_stall_req == $past(ep_stall_req))); // R4

  AST_HW_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_src != '0) |=> ((ep_stall_req & $past(clr_src)) == '0)); // R5

  AST_TOGGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ep_toggle_rst)); // R7

  AST_FIFO_RST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd2)
    |=> (ep_fifo_rst[RST_EP-1:0] == $past(bus_wdata[RST_EP-1:0]))); // R8

  AST_BAD_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 2'd1 && int'(sel_q) >= NUM_EP) |=> $stable(ep_enable)); // R10

  AST_BAD_SEL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd1 && int'(sel_q) >= NUM_EP) |-> (bus_rdata == 8'h00)); // R10

endmodule

bind usb_ep_ctl_bank usb_ep_ctl_bank_chk #(
  .NUM_EP(NUM_EP),
  .RST_EP(RST_EP),
  .SEL_W (SEL_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_addr       (bus_addr),
  .bus_we         (bus_we),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .evt_stall_sent (evt_stall_sent),
  .evt_setup_rx   (evt_setup_rx),
  .ep_enable      (ep_enable),
  .ep_stall_req   (ep_stall_req),
  .ep_toggle_rst  (ep_toggle_rst),
  .ep_fifo_rst    (ep_fifo_rst),
  .sel_q          (sel_q)
);

// File: tb/usb_ep_ctl_bank_tb.sv
`timescale 1ns/1ps
module usb_ep_ctl_bank_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [6:0] evt_stall_sent = '0;
  logic [6:0] evt_setup_rx = '0;
  logic [6:0] ep_enable, ep_stall_req, ep_toggle_rst, ep_fifo_rst;

  always #2.5 clk = ~clk;

  usb_ep_ctl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_stall_sent(evt_stall_sent), .evt_setup_rx(evt_setup_rx),
    .ep_enable(ep_enable), .ep_stall_req(ep_stall_req),
    .ep_toggle_rst(ep_toggle_rst), .ep_fifo_rst(ep_fifo_rst)
  );

  int    n_run = 0;
  int    n_fail = 0;
  string tag_force = "";

  // Reference state
  logic [2:0] m_sel = '0;
  logic [6:0] m_en = '0, m_st = '0, m_tgl = '0;
  logic [4:0] m_frst = '0;

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0: return {5'b0, m_sel};
      2'd1: return (m_sel == 3'd7) ? 8'h00 : {2'b0, m_st[m_sel], 4'b0, m_en[m_sel]};
      2'd2: return {3'b0, m_frst};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string read_tag(input logic [1:0] a);
    if (a == 2'd1) return (m_sel == 3'd7) ? "R10" : "R3";
    if (a == 2'd2) return "R8";
    return "R2";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    string t;
    t = (tag_force != "") ? tag_force : tag;
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", t, act, exp);
    end
  endtask

  task automatic chk_outputs();
    chk("R3", {1'b0, ep_enable},     {1'b0, m_en});
    chk("R5", {1'b0, ep_stall_req},  {1'b0, m_st});
    chk("R7", {1'b0, ep_toggle_rst}, {1'b0, m_tgl});
    chk("R8", {1'b0, ep_fifo_rst},   {3'b0, m_frst});
  endtask

  // One bus cycle: check state, drive, check read, then advance the model.
  task automatic step(input logic [1:0] a, input logic we, input logic [7:0] d,
                      input logic [6:0] ss, input logic [6:0] su);
    logic [6:0] hit;
    logic [6:0] drop;
    logic [6:0] arm;
    @(negedge clk);
    chk_outputs();
    bus_addr = a; bus_we = we; bus_wdata = d;
    evt_stall_sent = ss; evt_setup_rx = su;
    #1;
    chk(read_tag(a), bus_rdata, exp_read(a));
    @(posedge clk);
    hit = '0;
    if (we && a == 2'd1 && m_sel != 3'd7) hit[m_sel] = 1'b1;
    drop = ss | su | (d[4] ? hit : 7'b0);
    arm  = d[5] ? hit : 7'b0;
    m_st  = (m_st | arm) & ~drop;
    m_en  = (m_en & ~hit) | (d[0] ? hit : 7'b0);
    m_tgl = d[3] ? hit : 7'b0;
    if (we && a == 2'd0) m_sel = d[2:0];
    if (we && a == 2'd2) m_frst = d[4:0];
  endtask

  logic done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset image on every output and address
    tag_force = "R1";
    for (int a = 0; a < 4; a++) step(2'(a), 1'b0, 8'h00, '0, '0);
    tag_force = "";

    // R2: upper index bits dropped
    step(2'd0, 1'b1, 8'hFA, '0, '0);
    step(2'd0, 1'b0, 8'h00, '0, '0);
    // R4: arm on endpoint 2, then a bit-5-clear write keeps it
    step(2'd0, 1'b1, 8'h02, '0, '0);
    tag_force = "R4";
    step(2'd1, 1'b1, 8'h21, '0, '0);
    step(2'd1, 1'b1, 8'h01, '0, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0);
    // R6: cancel by bit 4
    tag_force = "R6";
    step(2'd1, 1'b1, 8'h11, '0, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0);
    // R9: set and hardware clear together; then set and cancel in one write
    tag_force = "R9";
    step(2'd1, 1'b1, 8'h21, '0, 7'b000_0100);
    step(2'd1, 1'b1, 8'h31, 7'b000_0100, '0);
    step(2'd1, 1'b1, 8'h31, '0, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0);
    // R5: arm then STALL-sent event
    tag_force = "R5";
    step(2'd1, 1'b1, 8'h20, '0, '0);
    step(2'd1, 1'b0, 8'h00, 7'b000_0100, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0);
    // R7: toggle pulse
    tag_force = "R7";
    step(2'd1, 1'b1, 8'h08, '0, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0);
    // R8: FIFO reset bits
    tag_force = "R8";
    step(2'd2, 1'b1, 8'hFF, '0, '0);
    step(2'd2, 1'b0, 8'h00, '0, '0);
    step(2'd2, 1'b1, 8'h00, '0, '0);
    // R10: index 7 reads zero and ignores writes
    tag_force = "R10";
    step(2'd0, 1'b1, 8'h07, '0, '0);
    step(2'd1, 1'b1, 8'h29, '0, '0);
    step(2'd1, 1'b0, 8'h00, '0, '0);
    tag_force = "";

    // Random phase with frequent set/clear collisions
    for (int k = 0; k < 4000; k++) begin
      logic [1:0] a;
      logic [7:0] d;
      logic [6:0] ss, su;
      a  = 2'($urandom_range(0, 3));
      d  = 8'($urandom);
      if ($urandom_range(0, 1) == 1) d[5] = 1'b1;
      ss = '0; su = '0;
      for (int i = 0; i < 7; i++) begin
        ss[i] = ($urandom_range(0, 9) == 0);
        su[i] = ($urandom_range(0, 9) == 0);
      end
      step(a, $urandom_range(0, 1) == 1, d, ss, su);
    end
    @(negedge clk);
    chk_outputs();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule